// File: doc/BRIEF.md
# Four-Lane DMA Byte FIFO with Stored Parity

This block is the byte buffer that sits between a host-side DMA engine and a peripheral-side data path. Diagnostic code reaches it through register-style ports. The storage is split into separately addressed byte lanes. Every entry holds a data byte together with the parity bit that travelled with it, and each lane is filled and drained on its own.

A write to the data port pushes one byte into the lane that the lane-select bits name. Those select bits come from two places: the low bit(s) from one control field and the top bit from a separate control register. The parity bit stored with the byte is not computed here; it is copied from a fixed bit of a parity-in control value. A pop reads the oldest byte of the selected lane into a registered data output. The parity of that byte appears on a fixed bit of a status byte. A nibble of per-lane empty flags and an aggregate empty flag are computed live from the lane counts. A soft-clear strobe returns every lane to empty.

Top module: `dma_lane_fifo`

## Requirements
- R1: After reset, `lane_empty` reads 0xF, `fifo_empty` is 1, and `pop_data` and `pop_stat` are zero.
- R2: A push goes to the lane whose index is {`sel_hi`, `sel_lo`}, with `sel_hi` as the most significant bit. So `sel_hi`=1 and `sel_lo`=0 selects lane 2.
- R3: The parity stored with a pushed byte is bit 3 of `par_ctl` at the push edge. No other bit of `par_ctl` has any effect.
- R4: A pop returns the oldest byte of the selected lane on `pop_data` from the cycle after the `pop_en` edge. The stored parity appears on bit 3 of `pop_stat`, and every other bit of `pop_stat` is zero.
- R5: Bit i of `lane_empty` is 1 exactly when lane i holds no entries, and it updates in the cycle after the push or pop edge.
- R6: `fifo_empty` is 1 exactly when all lanes are empty, and it updates in the same cycle as `lane_empty`.
- R7: Each lane holds 16 entries. A push into a full lane is ignored and leaves the stored contents unchanged.
- R8: A pop from an empty lane gives `pop_data`=0 and parity 0, and moves no pointer. A later push followed by a pop returns the pushed byte.
- R9: Lanes are independent. Pushes and pops on one lane do not change the order or contents of another lane.
- R10: A `soft_clr` edge empties all lanes and zeroes `pop_data` and `pop_stat`. It takes priority over a push or pop in the same cycle.
- R11: A push and a pop on the same non-full lane in one cycle both take effect. The pop returns the previous head, or zero if the lane was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_clr | input | 1 | Strobe that empties all lanes |
| push_en | input | 1 | Data-port write strobe |
| pop_en | input | 1 | Data-port read strobe |
| sel_lo | input | 1 | Low lane-select bit(s) |
| sel_hi | input | 1 | Top lane-select bit from the separate control register |
| push_data | input | 8 | Byte to push |
| par_ctl | input | 8 | Parity-in control value; bit 3 is the stored parity |
| pop_data | output | 8 | Byte returned by the last pop |
| pop_stat | output | 8 | Status byte; bit 3 is the popped parity |
| lane_empty | output | 4 | Per-lane empty flags |
| fifo_empty | output | 1 | All lanes empty |

## Verification
The bench builds the block with its default parameters: four lanes, sixteen entries per lane, eight-bit data, and parity on bit 3. With these values a lane reaches full after a short run of sixteen pushes, so the ignored seventeenth push and the drain back to empty both come within reach. Every lane-select combination, including the top select bit, can also be driven, and the parity-bit position is the one the control and status encodings fix.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
   localparam int DEF_LANES   = 4;
   localparam int DEF_DEPTH   = 16;
   localparam int DEF_DW      = 8;
   localparam int DEF_STAT_W  = 8;
   localparam int DEF_PAR_BIT = 3;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/dlf_dec.sv
module dlf_dec #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [W-1:0] idx,
   input  logic         en,
   output logic [N-1:0] oh
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign oh[i] = en && (idx == W'(i));
   end
endmodule

// File: rtl/dlf_lane.sv
module dlf_lane #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic [DW:0]   wdat,
   input  logic          rd,
   output logic [DW:0]   head,
   output logic [CW-1:0] cnt,
   output logic          empty,
   output logic          full
);
   logic [DW:0]   mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic          do_wr, do_rd;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign head  = empty ? '0 : mem[rp];

   // pointer wrap: free binary roll-over when depth fills the pointer range
   if (DEPTH == (1 << AW)) begin : g_wrap_bin
      assign wp_nxt = wp + 1'b1;
      assign rp_nxt = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nxt = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nxt = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= wp_nxt;
         if (do_rd) rp <= rp_nxt;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr && !clr) mem[wp] <= wdat;
   end
endmodule

// File: rtl/dma_lane_fifo.sv
module dma_lane_fifo #(
   parameter int NUM_LANES = dlf_pkg::DEF_LANES,
   parameter int DEPTH     = dlf_pkg::DEF_DEPTH,
   parameter int DW        = dlf_pkg::DEF_DW,
   parameter int STAT_W    = dlf_pkg::DEF_STAT_W,
   parameter int PAR_BIT   = dlf_pkg::DEF_PAR_BIT,
   localparam int LANE_W   = $clog2(NUM_LANES),
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_clr,
   input  logic                 push_en,
   input  logic                 pop_en,
   input  logic [LANE_W-2:0]    sel_lo,
   input  logic                 sel_hi,
   input  logic [DW-1:0]        push_data,
   input  logic [STAT_W-1:0]    par_ctl,
   output logic [DW-1:0]        pop_data,
   output logic [STAT_W-1:0]    pop_stat,
   output logic [NUM_LANES-1:0] lane_empty,
   output logic                 fifo_empty
);
   if (!dlf_pkg::is_pow2(NUM_LANES) || NUM_LANES < 4) begin : g_bad_lanes
      $error("NUM_LANES must be a power of two of at least 4");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (PAR_BIT >= STAT_W) begin : g_bad_par
      $error("PAR_BIT must lie inside the status byte");
   end

   logic [LANE_W-1:0]       lane_idx;
   logic [NUM_LANES-1:0]    push_oh, pop_oh, lane_full;
   logic [DW:0]             head [NUM_LANES];
   logic [NUM_LANES*CW-1:0] cnt_flat;
   logic [DW:0]             sel_head;
   logic [STAT_W-1:0]       stat_nxt;

   assign lane_idx = {sel_hi, sel_lo};

   dlf_dec #(.N(NUM_LANES), .W(LANE_W)) u_push_dec (
      .idx(lane_idx), .en(push_en), .oh(push_oh));
   dlf_dec #(.N(NUM_LANES), .W(LANE_W)) u_pop_dec (
      .idx(lane_idx), .en(pop_en), .oh(pop_oh));

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      dlf_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (soft_clr),
         .wr    (push_oh[i]),
         .wdat  ({par_ctl[PAR_BIT], push_data}),
         .rd    (pop_oh[i]),
         .head  (head[i]),
         .cnt   (cnt_flat[i*CW +: CW]),
         .empty (lane_empty[i]),
         .full  (lane_full[i])
      );
   end

   assign sel_head   = head[lane_idx];
   assign fifo_empty = &lane_empty;

   always_comb begin
      stat_nxt          = '0;
      stat_nxt[PAR_BIT] = sel_head[DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data <= '0;
         pop_stat <= '0;
      end else if (soft_clr) begin
         pop_data <= '0;
         pop_stat <= '0;
      end else if (pop_en) begin
         pop_data <= sel_head[DW-1:0];
         pop_stat <= stat_nxt;
      end
   end
endmodule

// File: rtl/dlf_chk.sv
module dlf_chk #(
   parameter int NUM_LANES = 4,
   parameter int DEPTH     = 16,
   parameter int DW        = 8,
   parameter int STAT_W    = 8,
   parameter int PAR_BIT   = 3,
   parameter int LANE_W    = 2,
   parameter int CW        = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    soft_clr,
   input logic                    push_en,
   input logic                    pop_en,
   input logic [LANE_W-1:0]       lane_idx,
   input logic [DW-1:0]           pop_data,
   input logic [STAT_W-1:0]       pop_stat,
   input logic [NUM_LANES-1:0]    lane_empty,
   input logic                    fifo_empty,
   input logic [NUM_LANES*CW-1:0] cnt_flat
);
   localparam logic [STAT_W-1:0] PMASK = STAT_W'(1) << PAR_BIT;

   // R10
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (lane_empty == '1) && fifo_empty && (pop_data == '0) && (pop_stat == '0));

   // R8
   empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !soft_clr && lane_empty[lane_idx]) |=> (pop_data == '0) && (pop_stat == '0));

   // R4
   stat_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_stat & ~PMASK) == '0);

   // R6
   all_empty_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> (cnt_flat == '0));

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      // R7
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_flat[i*CW +: CW] <= CW'(DEPTH));

      // R7
      full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (push_en && !pop_en && !soft_clr && lane_idx == LANE_W'(i)
          && cnt_flat[i*CW +: CW] == CW'(DEPTH)) |=> $stable(cnt_flat[i*CW +: CW]));
   end
endmodule

bind dma_lane_fifo dlf_chk #(
   .NUM_LANES(NUM_LANES), .DEPTH(DEPTH), .DW(DW), .STAT_W(STAT_W),
   .PAR_BIT(PAR_BIT), .LANE_W(LANE_W), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .push_en(push_en),
   .pop_en(pop_en), .lane_idx(lane_idx), .pop_data(pop_data),
   .pop_stat(pop_stat), .lane_empty(lane_empty), .fifo_empty(fifo_empty),
   .cnt_flat(cnt_flat)
);

// File: tb/dma_lane_fifo_tb.sv
module dma_lane_fifo_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       soft_clr = 0, push_en = 0, pop_en = 0;
   logic [0:0] sel_lo = '0;
   logic       sel_hi = 0;
   logic [7:0] push_data = '0, par_ctl = '0;
   logic [7:0] pop_data, pop_stat;
   logic [3:0] lane_empty;
   logic       fifo_empty;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [8:0] mq [4][$];
   logic [8:0] exp_q [$];
   string      req_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_lane_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .push_en(push_en),
      .pop_en(pop_en), .sel_lo(sel_lo), .sel_hi(sel_hi),
      .push_data(push_data), .par_ctl(par_ctl), .pop_data(pop_data),
      .pop_stat(pop_stat), .lane_empty(lane_empty), .fifo_empty(fifo_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: compares pop results against the scoreboard
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         logic [8:0] e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         chk(pop_data == e[7:0], {r, " data"}, pop_data, e[7:0]);
         chk(pop_stat == {4'b0, e[8], 3'b0}, {r, " status"}, pop_stat, {4'b0, e[8], 3'b0});
      end
   end

   task automatic sel(input int lane);
      sel_hi = lane[1];
      sel_lo = lane[0];
   endtask

   task automatic push(input int lane, input logic [7:0] d, input logic p);
      @(negedge clk);
      sel(lane);
      push_en = 1; push_data = d;
      par_ctl = p ? 8'h08 : 8'hF7;   // R3: only bit 3 counts
      if (mq[lane].size() < DEPTH) mq[lane].push_back({p, d});
      @(posedge clk); #1;
      push_en = 0;
   endtask

   task automatic pop(input int lane, input string req);
      logic [8:0] e;
      @(negedge clk);
      sel(lane);
      pop_en = 1;
      e = (mq[lane].size() > 0) ? mq[lane].pop_front() : 9'h0;
      @(posedge clk); #1;
      pop_en = 0;
      exp_q.push_back(e);
      req_q.push_back(req);
   endtask

   task automatic pushpop(input int lane, input logic [7:0] d, input logic p);
      logic [8:0] e;
      bit was_full;
      @(negedge clk);
      sel(lane);
      push_en = 1; pop_en = 1; push_data = d; par_ctl = p ? 8'h08 : 8'h00;
      was_full = (mq[lane].size() >= DEPTH);
      e = (mq[lane].size() > 0) ? mq[lane].pop_front() : 9'h0;
      if (!was_full) mq[lane].push_back({p, d});
      @(posedge clk); #1;
      push_en = 0; pop_en = 0;
      exp_q.push_back(e);
      req_q.push_back("R11");
   endtask

   task automatic chk_flags(input string req);
      logic [3:0] ef;
      @(negedge clk);
      for (int i = 0; i < 4; i++) ef[i] = (mq[i].size() == 0);
      chk(lane_empty == ef, {req, " lane_empty"}, lane_empty, ef);
      chk(fifo_empty == (&ef), {req, " fifo_empty"}, fifo_empty, &ef);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      @(negedge clk);
      chk(lane_empty == 4'hF, "R1 lane_empty", lane_empty, 4'hF);
      chk(fifo_empty == 1'b1, "R1 fifo_empty", fifo_empty, 1);
      chk(pop_data == 8'h00, "R1 pop_data", pop_data, 0);
      chk(pop_stat == 8'h00, "R1 pop_stat", pop_stat, 0);

      // R2 R3 R5 R6: lane selection incl. top select bit, parity from bit 3
      push(2, 8'hA5, 1);
      chk_flags("R2 R5");
      chk(lane_empty == 4'b1011, "R2 lane2 selected", lane_empty, 4'b1011);
      push(0, 8'h3C, 0);
      push(3, 8'h81, 1);
      push(1, 8'h7E, 0);
      chk_flags("R6");
      push(2, 8'h5A, 0);
      // R4 R3: oldest first with parity on status bit 3
      pop(2, "R4 R3");
      pop(2, "R4 R3");
      pop(3, "R3");
      pop(0, "R4");
      pop(1, "R4");
      chk_flags("R5 R6 drained");

      // R7: fill lane 1, extra push ignored
      for (int k = 0; k < DEPTH; k++) push(1, 8'(8'h10 + k), k[0]);
      push(1, 8'hEE, 1);
      chk_flags("R7 full");
      for (int k = 0; k < DEPTH; k++) pop(1, "R7");
      // R8 empty pop
      pop(1, "R8");
      chk_flags("R8");
      push(1, 8'h42, 1);
      pop(1, "R8 after empty pop");

      // R11 simultaneous push and pop
      pushpop(3, 8'h99, 1);
      chk_flags("R11");
      push(3, 8'h11, 0);
      pushpop(3, 8'h22, 1);
      pop(3, "R11");
      pop(3, "R11");

      // R9 interleaved lanes
      for (int k = 0; k < 6; k++) push(k % 4, 8'(8'hC0 + k), k[1]);
      pop(1, "R9"); pop(0, "R9"); pop(0, "R9"); pop(3, "R9");
      chk_flags("R9");
      pop(2, "R9"); pop(1, "R9");
      chk_flags("R9");

      // R10 soft clear beats a push in the same cycle
      push(0, 8'h12, 1);
      push(2, 8'h34, 1);
      pop(2, "R10 pre");
      push(2, 8'h56, 1);
      @(negedge clk);
      soft_clr = 1; push_en = 1; sel(1); push_data = 8'h77; par_ctl = 8'h08;
      @(posedge clk); #1;
      soft_clr = 0; push_en = 0;
      for (int i = 0; i < 4; i++) mq[i].delete();
      @(negedge clk);
      chk(pop_data == 8'h00, "R10 pop_data", pop_data, 0);
      chk(pop_stat == 8'h00, "R10 pop_stat", pop_stat, 0);
      chk_flags("R10");
      pop(1, "R10");
      pop(2, "R10");

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule